// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block holds the load queue of an out-of-order core and finds loads that read memory too early. Every slot records the load's shared sequence number, the 8-byte-aligned chunk address it reads, a byte-enable mask, whether it has executed, and, when it took its data from an in-flight store, that store's sequence number. Slots are allocated at the tail in program order and freed from the head at retirement.

When a store resolves its address, or later when its data arrives, the core presents the store's sequence number, chunk address and byte mask. The block marks every live load that is younger than the store, has already executed, shares at least one byte with the store, and did not forward from this same store. One cycle later it reports the whole set as a bit vector, together with a valid pulse and the slot index of the oldest offender, counted from the queue head. The core uses that report to re-execute dependent work. Sending the same store a second time after its data phase catches loads that executed between the two phases.

Top module: `lqv_detector`

## Requirements
- R1: After reset the queue is empty (`lq_empty`=1, `lq_full`=0), `alloc_idx` is 0 and no violation is reported.
- R2: An accepted allocation writes slot `alloc_idx` and advances it by one modulo DEPTH. `lq_full` rises after DEPTH net allocations, and while full an allocation request is ignored: neither the pointer nor any slot changes.
- R3: A retire request frees the head slot and advances the head. On an empty queue it is ignored, so the next allocation still clears `lq_empty`.
- R4: A load is a candidate only when it is younger than the store: (load_seq - store_seq) mod 2^SEQW is non-zero and has its top bit clear.
- R5: Only allocated loads that have executed can be flagged. An execute update aimed at a free slot is ignored.
- R6: A load whose data came from the store with the same sequence number is not flagged. A load that forwarded from any other store is still flagged.
- R7: Overlap means equal chunk addresses and a non-zero AND of the two byte masks.
- R8: The cycle after a check request, `viol_vec` bit j is set exactly for the flagged slots. `viol_valid` is 1 if any bit is set. `viol_idx` is the flagged slot reached first when walking from the head towards the tail.
- R9: A cycle with no check request leaves `viol_valid` at 0 and `viol_vec` at 0 in the following cycle, so every report is a one-cycle pulse.
- R10: Repeating a check for the same store after a further load has executed flags that load too. This is the second-phase search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_seq | input | SEQW | Sequence number of the allocated load |
| alloc_idx | output | IDXW | Slot the next allocation will use |
| lq_full | output | 1 | All slots allocated |
| lq_empty | output | 1 | No slot allocated |
| retire_valid | input | 1 | Free the head slot |
| ld_exec_valid | input | 1 | A load has executed |
| ld_exec_idx | input | IDXW | Slot of the executed load |
| ld_exec_chunk | input | CHW | Chunk address read by the load |
| ld_exec_mask | input | BYTES | Bytes read within the chunk |
| ld_exec_fwd | input | 1 | Load took its data from a store |
| ld_exec_fwd_seq | input | SEQW | Sequence number of that store |
| st_chk_valid | input | 1 | Run a violation search for a store |
| st_chk_seq | input | SEQW | Store sequence number |
| st_chk_chunk | input | CHW | Store chunk address |
| st_chk_mask | input | BYTES | Bytes written within the chunk |
| viol_valid | output | 1 | One-cycle pulse: at least one violation |
| viol_idx | output | IDXW | Oldest violating slot |
| viol_vec | output | DEPTH | All violating slots |

## Verification
The assertions check on every cycle the properties that hold one slot at a time. They confirm that a reported slot had executed, matched the store's chunk with a common byte, and did not forward from that store. They also confirm that the oldest index lies inside the reported vector, that an idle cycle yields an empty report, and that the occupancy count stays in range and holds when a request is refused. The bench shows what no single-cycle property captures. It sweeps every store sequence number across several chunks and masks, including points where sequence numbers wrap, and that sweep establishes the age rule and the choice of the oldest slot as the head moves around the ring. Its scenarios also cover the second-phase rescan, refused allocations and retirements, and execute updates sent to free slots.

// File: rtl/lqv_pkg.sv
package lqv_pkg;

    // Per-slot status bits of the load queue
    typedef struct packed {
        logic live;     // slot allocated
        logic done;     // load has executed
        logic fwd;      // load took data from an in-flight store
    } slot_flags_t;

    localparam slot_flags_t SLOT_FREE = '{live: 1'b0, done: 1'b0, fwd: 1'b0};

endpackage

// File: rtl/lqv_ring.sv
module lqv_ring #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic            retire_req,
    output logic [IDXW-1:0] head,
    output logic [IDXW-1:0] tail,
    output logic            full,
    output logic            empty,
    output logic            do_alloc,
    output logic            do_retire
);
    typedef struct packed {
        logic [IDXW-1:0] head;
        logic [IDXW-1:0] tail;
        logic [CNTW-1:0] count;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d    = ring_q;
        empty     = (ring_q.count == '0);
        full      = (ring_q.count == CNTW'(DEPTH));
        do_alloc  = alloc_req && !full;
        do_retire = retire_req && !empty;
        if (do_alloc) begin
            ring_d.tail = ring_q.tail + 1'b1;
        end
        if (do_retire) begin
            ring_d.head = ring_q.head + 1'b1;
        end
        case ({do_alloc, do_retire})
            2'b10:   ring_d.count = ring_q.count + 1'b1;
            2'b01:   ring_d.count = ring_q.count - 1'b1;
            default: ring_d.count = ring_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign head = ring_q.head;
    assign tail = ring_q.tail;

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ring_q.count <= CNTW'(DEPTH));

    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !retire_req) |=> (full && $stable(tail)));

    a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !alloc_req) |=> (empty && $stable(head)));

endmodule

// File: rtl/lqv_slot_cmp.sv
module lqv_slot_cmp #(
    parameter int SEQW  = 5,
    parameter int CHW   = 8,
    parameter int BYTES = 8
) (
    input  logic             eligible,
    input  logic [SEQW-1:0]  ld_seq,
    input  logic [CHW-1:0]   ld_chunk,
    input  logic [BYTES-1:0] ld_mask,
    input  logic             ld_fwd,
    input  logic [SEQW-1:0]  ld_fwd_seq,
    input  logic [SEQW-1:0]  st_seq,
    input  logic [CHW-1:0]   st_chunk,
    input  logic [BYTES-1:0] st_mask,
    output logic             hit
);
    logic [SEQW-1:0] age_gap;
    logic            younger;
    logic            overlap;
    logic            own_src;

    always_comb begin
        age_gap = ld_seq - st_seq;
        younger = (age_gap != '0) && !age_gap[SEQW-1];
        overlap = (ld_chunk == st_chunk) && ((ld_mask & st_mask) != '0);
        own_src = ld_fwd && (ld_fwd_seq == st_seq);
        hit     = eligible && younger && overlap && !own_src;
    end

endmodule

// File: rtl/lqv_oldest.sv
module lqv_oldest #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vec,
    input  logic [IDXW-1:0]  head,
    output logic             found,
    output logic [IDXW-1:0]  idx
);
    logic [IDXW-1:0] pos;

    // Walk from the youngest distance down to zero so the slot nearest the
    // head is written last and wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            pos = head + IDXW'(i);
            if (vec[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end

endmodule

// File: rtl/lqv_detector.sv
module lqv_detector
    import lqv_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQW  = 5,
    parameter int CHW   = 8,
    parameter int BYTES = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [SEQW-1:0]  alloc_seq,
    output logic [IDXW-1:0]  alloc_idx,
    output logic             lq_full,
    output logic             lq_empty,
    input  logic             retire_valid,
    input  logic             ld_exec_valid,
    input  logic [IDXW-1:0]  ld_exec_idx,
    input  logic [CHW-1:0]   ld_exec_chunk,
    input  logic [BYTES-1:0] ld_exec_mask,
    input  logic             ld_exec_fwd,
    input  logic [SEQW-1:0]  ld_exec_fwd_seq,
    input  logic             st_chk_valid,
    input  logic [SEQW-1:0]  st_chk_seq,
    input  logic [CHW-1:0]   st_chk_chunk,
    input  logic [BYTES-1:0] st_chk_mask,
    output logic             viol_valid,
    output logic [IDXW-1:0]  viol_idx,
    output logic [DEPTH-1:0] viol_vec
);
    typedef struct packed {
        logic             valid;
        logic [IDXW-1:0]  idx;
        logic [DEPTH-1:0] vec;
    } report_t;

    slot_flags_t      flags_d [DEPTH];
    slot_flags_t      flags_q [DEPTH];
    logic [SEQW-1:0]  seq_d   [DEPTH];
    logic [SEQW-1:0]  seq_q   [DEPTH];
    logic [CHW-1:0]   chunk_d [DEPTH];
    logic [CHW-1:0]   chunk_q [DEPTH];
    logic [BYTES-1:0] mask_d  [DEPTH];
    logic [BYTES-1:0] mask_q  [DEPTH];
    logic [SEQW-1:0]  fseq_d  [DEPTH];
    logic [SEQW-1:0]  fseq_q  [DEPTH];
    report_t          rep_d, rep_q;

    logic [IDXW-1:0]  head, tail;
    logic             do_alloc, do_retire;
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] done_vec;
    logic             any_hit;
    logic [IDXW-1:0]  oldest_idx;

    lqv_ring #(.DEPTH(DEPTH)) i_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_valid),
        .retire_req (retire_valid),
        .head       (head),
        .tail       (tail),
        .full       (lq_full),
        .empty      (lq_empty),
        .do_alloc   (do_alloc),
        .do_retire  (do_retire)
    );

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        assign done_vec[j] = flags_q[j].live && flags_q[j].done;

        lqv_slot_cmp #(.SEQW(SEQW), .CHW(CHW), .BYTES(BYTES)) i_cmp (
            .eligible   (done_vec[j]),
            .ld_seq     (seq_q[j]),
            .ld_chunk   (chunk_q[j]),
            .ld_mask    (mask_q[j]),
            .ld_fwd     (flags_q[j].fwd),
            .ld_fwd_seq (fseq_q[j]),
            .st_seq     (st_chk_seq),
            .st_chunk   (st_chk_chunk),
            .st_mask    (st_chk_mask),
            .hit        (hit_vec[j])
        );
    end

    lqv_oldest #(.DEPTH(DEPTH)) i_oldest (
        .vec   (hit_vec),
        .head  (head),
        .found (any_hit),
        .idx   (oldest_idx)
    );

    always_comb begin
        flags_d = flags_q;
        seq_d   = seq_q;
        chunk_d = chunk_q;
        mask_d  = mask_q;
        fseq_d  = fseq_q;

        // Execute update first; a free slot ignores it.
        if (ld_exec_valid && flags_q[ld_exec_idx].live) begin
            flags_d[ld_exec_idx].done = 1'b1;
            flags_d[ld_exec_idx].fwd  = ld_exec_fwd;
            chunk_d[ld_exec_idx]      = ld_exec_chunk;
            mask_d[ld_exec_idx]       = ld_exec_mask;
            fseq_d[ld_exec_idx]       = ld_exec_fwd_seq;
        end
        if (do_retire) begin
            flags_d[head] = SLOT_FREE;
        end
        if (do_alloc) begin
            flags_d[tail]      = SLOT_FREE;
            flags_d[tail].live = 1'b1;
            seq_d[tail]        = alloc_seq;
        end

        rep_d.valid = st_chk_valid && any_hit;
        rep_d.idx   = st_chk_valid ? oldest_idx : '0;
        rep_d.vec   = st_chk_valid ? hit_vec : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                flags_q[j] <= SLOT_FREE;
                seq_q[j]   <= '0;
                chunk_q[j] <= '0;
                mask_q[j]  <= '0;
                fseq_q[j]  <= '0;
            end
            rep_q <= '0;
        end else begin
            flags_q <= flags_d;
            seq_q   <= seq_d;
            chunk_q <= chunk_d;
            mask_q  <= mask_d;
            fseq_q  <= fseq_d;
            rep_q   <= rep_d;
        end
    end

    assign alloc_idx  = tail;
    assign viol_valid = rep_q.valid;
    assign viol_idx   = rep_q.idx;
    assign viol_vec   = rep_q.vec;

    a_r8_oldest_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> viol_vec[viol_idx]);

    a_r8_valid_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_vec != '0));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !st_chk_valid |=> (!viol_valid && viol_vec == '0));

    a_r5_only_executed: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> ((viol_vec & ~$past(done_vec)) == '0));

    for (genvar j = 0; j < DEPTH; j++) begin : g_chk
        a_r7_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            viol_vec[j] |-> $past((chunk_q[j] == st_chk_chunk) &&
                                  ((mask_q[j] & st_chk_mask) != '0)));

        a_r6_not_own_store: assert property (@(posedge clk) disable iff (!rst_n)
            viol_vec[j] |-> $past(!(flags_q[j].fwd && fseq_q[j] == st_chk_seq)));
    end

endmodule

// File: tb/test_lqv_detector.sv
module test_lqv_detector;
    localparam int DEPTH = 8;
    localparam int SEQW  = 5;
    localparam int CHW   = 8;
    localparam int BYTES = 8;
    localparam int IDXW  = 3;
    localparam int SEQM  = 1 << SEQW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [SEQW-1:0]  alloc_seq = '0;
    logic [IDXW-1:0]  alloc_idx;
    logic             lq_full, lq_empty;
    logic             retire_valid = 1'b0;
    logic             ld_exec_valid = 1'b0;
    logic [IDXW-1:0]  ld_exec_idx = '0;
    logic [CHW-1:0]   ld_exec_chunk = '0;
    logic [BYTES-1:0] ld_exec_mask = '0;
    logic             ld_exec_fwd = 1'b0;
    logic [SEQW-1:0]  ld_exec_fwd_seq = '0;
    logic             st_chk_valid = 1'b0;
    logic [SEQW-1:0]  st_chk_seq = '0;
    logic [CHW-1:0]   st_chk_chunk = '0;
    logic [BYTES-1:0] st_chk_mask = '0;
    logic             viol_valid;
    logic [IDXW-1:0]  viol_idx;
    logic [DEPTH-1:0] viol_vec;

    always #5 clk = ~clk;

    lqv_detector #(.DEPTH(DEPTH), .SEQW(SEQW), .CHW(CHW), .BYTES(BYTES)) i_lqv_detector (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
        .lq_full(lq_full), .lq_empty(lq_empty), .retire_valid(retire_valid),
        .ld_exec_valid(ld_exec_valid), .ld_exec_idx(ld_exec_idx),
        .ld_exec_chunk(ld_exec_chunk), .ld_exec_mask(ld_exec_mask),
        .ld_exec_fwd(ld_exec_fwd), .ld_exec_fwd_seq(ld_exec_fwd_seq),
        .st_chk_valid(st_chk_valid), .st_chk_seq(st_chk_seq),
        .st_chk_chunk(st_chk_chunk), .st_chk_mask(st_chk_mask),
        .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_vec(viol_vec)
    );

    int vectors = 0;
    int miscompares = 0;

    // Reference model of the queue contents, kept from the stimulus alone
    bit m_live [DEPTH];
    bit m_done [DEPTH];
    bit m_fwd  [DEPTH];
    int m_seq  [DEPTH];
    int m_chunk[DEPTH];
    int m_mask [DEPTH];
    int m_fseq [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic do_alloc(input int seq);
        check("R2 alloc_idx", int'(alloc_idx), m_tail);
        alloc_valid = 1'b1;
        alloc_seq   = SEQW'(seq);
        @(negedge clk);
        alloc_valid = 1'b0;
        if (m_cnt < DEPTH) begin
            m_live[m_tail] = 1; m_done[m_tail] = 0; m_fwd[m_tail] = 0;
            m_seq[m_tail] = seq % SEQM;
            m_tail = (m_tail + 1) % DEPTH;
            m_cnt++;
        end
    endtask

    task automatic do_retire();
        retire_valid = 1'b1;
        @(negedge clk);
        retire_valid = 1'b0;
        if (m_cnt > 0) begin
            m_live[m_head] = 0; m_done[m_head] = 0; m_fwd[m_head] = 0;
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
        end
    endtask

    task automatic do_exec(input int idx, input int chunk, input int mask,
                           input bit fwd, input int fseq);
        ld_exec_valid   = 1'b1;
        ld_exec_idx     = IDXW'(idx);
        ld_exec_chunk   = CHW'(chunk);
        ld_exec_mask    = BYTES'(mask);
        ld_exec_fwd     = fwd;
        ld_exec_fwd_seq = SEQW'(fseq);
        @(negedge clk);
        ld_exec_valid = 1'b0;
        if (m_live[idx]) begin
            m_done[idx] = 1; m_fwd[idx] = fwd;
            m_chunk[idx] = chunk; m_mask[idx] = mask; m_fseq[idx] = fseq % SEQM;
        end
    endtask

    function automatic bit younger(input int ld, input int st);
        int gap = (ld - st + SEQM) % SEQM;
        return gap != 0 && gap < SEQM / 2;
    endfunction

    // Store search: report appears on the cycle after the request (R8),
    // then clears on the following idle cycle (R9).
    task automatic do_check(input int seq, input int chunk, input int mask, input string tag);
        int exp_vec = 0;
        int exp_idx = 0;
        bit exp_any = 0;
        for (int j = 0; j < DEPTH; j++) begin
            if (m_live[j] && m_done[j] && younger(m_seq[j], seq)
                && m_chunk[j] == chunk && (m_mask[j] & mask) != 0
                && !(m_fwd[j] && m_fseq[j] == seq))
                exp_vec |= (1 << j);
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            int p = (m_head + i) % DEPTH;
            if (exp_vec[p]) begin exp_any = 1; exp_idx = p; end
        end
        st_chk_valid = 1'b1;
        st_chk_seq   = SEQW'(seq);
        st_chk_chunk = CHW'(chunk);
        st_chk_mask  = BYTES'(mask);
        @(negedge clk);
        st_chk_valid = 1'b0;
        check({tag, " R4 R5 R6 R7 viol_vec"}, int'(viol_vec), exp_vec);
        check({tag, " R8 viol_valid"}, int'(viol_valid), int'(exp_any));
        if (exp_any) check({tag, " R8 viol_idx oldest"}, int'(viol_idx), exp_idx);
        @(negedge clk);
        check({tag, " R9 pulse ends"}, int'(viol_valid), 0);
        check({tag, " R9 vec clears"}, int'(viol_vec), 0);
    endtask

    task automatic sweep(input string tag);
        int masks[6] = '{8'h01, 8'h08, 8'h30, 8'h80, 8'hC0, 8'hFF};
        for (int s = 0; s < SEQM; s++)
            for (int c = 0; c < 3; c++)
                for (int m = 0; m < 6; m++)
                    do_check(s, c, masks[m], tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_and_end();
    end

    initial begin
        for (int j = 0; j < DEPTH; j++) begin
            m_live[j] = 0; m_done[j] = 0; m_fwd[j] = 0;
            m_seq[j] = 0; m_chunk[j] = 0; m_mask[j] = 0; m_fseq[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", int'(lq_empty), 1);
        check("R1 full", int'(lq_full), 0);
        check("R1 alloc_idx", int'(alloc_idx), 0);
        check("R1 viol_valid", int'(viol_valid), 0);

        // R2: fill the queue with loads at even sequence numbers 2..16
        for (int i = 0; i < DEPTH; i++) do_alloc(2 + 2 * i);
        check("R2 full", int'(lq_full), 1);
        do_alloc(31);                                  // refused while full
        check("R2 refused alloc_idx", int'(alloc_idx), 0);
        check("R2 still full", int'(lq_full), 1);

        // Execute all but slot 6; slot 2 forwarded from store 3, slot 5 from store 1
        for (int i = 0; i < DEPTH; i++) begin
            if (i != 6)
                do_exec(i, i % 3, (8'h03 << i) & 8'hFF, (i == 2) || (i == 5),
                        (i == 2) ? 3 : 1);
        end
        sweep("first");

        // R10: second-phase search catches slot 6 executing after the first search
        do_check(11, 0, 8'hFF, "R10 before");
        do_exec(6, 0, 8'h40, 0, 0);
        do_check(11, 0, 8'hFF, "R10 rescan");

        // R3 and wrap: free three slots, reuse them with later sequence numbers
        for (int i = 0; i < 3; i++) do_retire();
        check("R3 not full", int'(lq_full), 0);
        do_alloc(18); do_alloc(20); do_alloc(22);
        do_exec(0, 0, 8'hFF, 0, 0);
        do_exec(1, 1, 8'h0F, 1, 19);
        sweep("wrapped");

        // R5: free slot 3 then send an execute update to it
        do_retire();
        do_exec(3, 0, 8'hFF, 0, 0);
        do_check(1, 0, 8'hFF, "R5 free slot");
        do_alloc(24);
        do_check(1, 0, 8'hFF, "R5 realloc not executed");

        // R3: drain fully, then a refused retire must not corrupt occupancy
        while (m_cnt > 0) do_retire();
        check("R3 empty", int'(lq_empty), 1);
        do_retire();
        check("R3 refused retire", int'(lq_empty), 1);
        do_alloc(5);
        check("R3 not empty after alloc", int'(lq_empty), 0);
        check("R3 not full after one", int'(lq_full), 0);

        report_and_end();
    end

endmodule